// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared state of a multi-channel event timer: a 64-bit up-counter that can be stopped and restarted, a read-only capability word pair, a two-bit global configuration register and an interrupt status register. Software reaches all of it through 32-bit register accesses within a 1 KiB window. Addresses from 0x100 upward are decoded into a channel index and a word index and passed to the per-channel logic. That logic sits outside this block and supplies the read data for those words.

Requests arrive on a valid/ready channel and each accepted request returns exactly one response on a valid/ready channel one clock later. A read response carries the register value. A write response carries zero. The block holds a single response register, so a request is accepted only when that register is empty or is being drained in the same cycle. A stalled response therefore blocks further requests. Setting the enable bit restarts the counter from the value it held and issues a one-cycle arm pulse to channels. Clearing the enable bit freezes the count, issues a one-cycle disarm pulse to every channel and clears all pending status bits.

Top module: `etr_main_regs`

## Requirements
- R1: `req_ready` is high exactly when no response is pending or `rsp_ready` is high. Each accepted request gives one response in the following cycle. A stalled response keeps `rsp_valid` high and `rsp_rdata` unchanged. Write responses carry 0.
- R2: Reading 0x000 returns the base capability value with bits [12:8] replaced by the channel count minus one (0x8086A201 for three channels). Reading 0x004 returns the tick period parameter (0x00989680 by default). Writes to either address change nothing.
- R3: Word 0x010 holds bit 0 (count enable) and bit 1 (legacy routing, driven on `legacy_route`). Only these two bits are written, and every other bit reads 0. Word 0x014 always reads 0 and ignores writes.
- R4: While halted, the counter holds its value. Writes to 0x0F0 replace only the low 32 bits and writes to 0x0F4 replace only the high 32 bits. Reads return the held halves.
- R5: While enabled, the counter adds one every clock, with carry from the low half into the high half. A read returns the count as it stood just before the accepting clock edge. The count that `count_value` shows in the cycle after the enabling write is the held value.
- R6: A write that changes the enable bit from 0 to 1 raises `ch_arm[i]` for one cycle for every channel whose `ch_cmp_max[i]` is 0.
- R7: A write that changes the enable bit from 1 to 0 raises every `ch_disarm` bit for one cycle, freezes the counter at its value after that edge, and clears the status register.
- R8: Status word 0x020 bit i is set by `ist_set[i]` only while enabled. Writing 1 to a bit clears it, and writing 0 leaves it.
- R9: Address 0x100 + 0x20*i + 4*w, with i below the channel count and w from 0 to 5, raises only `ch_sel[i]` in the accepting cycle. `ch_word` gives w, and `ch_write` and `ch_wdata` pass through. A read returns word i of `ch_rdata`.
- R10: A channel index at or above the channel count, or a word index of 6 or 7, raises no `ch_sel` bit and reads 0.
- R11: Any other address, and any address with bits [1:0] non-zero, reads 0 and its write changes no state.
- R12: After reset the counter, configuration, status and pulses are 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| ch_sel | output | 3 | One-hot channel select for an accepted channel access |
| ch_write | output | 1 | Channel access is a write |
| ch_word | output | 3 | Word index within the channel stride |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 96 | Per-channel read data, channel i at bits [32i+31:32i] |
| ch_cmp_max | input | 3 | Channel comparator is all ones |
| ch_arm | output | 3 | One-cycle arm pulse per channel |
| ch_disarm | output | 3 | One-cycle disarm pulse per channel |
| ist_set | input | 3 | Per-channel status set request |
| count_en | output | 1 | Counter running |
| legacy_route | output | 1 | Legacy routing bit |
| count_value | output | 64 | Current counter value |

## Verification
The bench puts the counter just below a 32-bit boundary, enables it and reads the halves on consecutive cycles. A design that read the wrong cycle, or lost the carry, returns a low half off by one or a high half that has not advanced. It checks that enable edges arm only channels whose comparator is not at the maximum and disarm all channels. A design that armed on every write, or left status bits set after a halt, fails there. Out-of-range channel indices, unused channel words and unaligned addresses must read 0 without selecting a channel. A design that wraps the index would select a real channel. A stalled response must hold its data and block new requests, which exposes a design that overwrites its response register.

// File: rtl/etr_pkg.sv
package etr_pkg;
  localparam int ADDR_W     = 10;
  localparam int STRIDE_LSB = 5;
  localparam int IDX_W      = ADDR_W - STRIDE_LSB;
  localparam int WORD_W     = STRIDE_LSB - 2;
  localparam int CHAN_WORDS = 6;
  localparam int DATA_W     = 32;

  localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] CHAN_BASE  = 10'h100;

  typedef enum logic [3:0] {
    RG_NONE, RG_CAP_LO, RG_CAP_HI, RG_CFG_LO, RG_CFG_HI,
    RG_STAT, RG_CNT_LO, RG_CNT_HI, RG_CHAN
  } etr_region_e;
endpackage

// File: rtl/etr_decode.sv
module etr_decode
  import etr_pkg::*;
#(
  parameter int NT = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output etr_region_e       region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [IDX_W:0]   NT_L     = (IDX_W+1)'(NT);
  localparam logic [IDX_W-1:0] BASE_IDX = CHAN_BASE[ADDR_W-1:STRIDE_LSB];
  localparam logic [WORD_W:0]  WORDS_L  = (WORD_W+1)'(CHAN_WORDS);

  always_comb begin
    idx_o    = addr_i[ADDR_W-1:STRIDE_LSB] - BASE_IDX;
    word_o   = addr_i[STRIDE_LSB-1:2];
    region_o = RG_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i >= CHAN_BASE) begin
        if (({1'b0, idx_o} < NT_L) && ({1'b0, word_o} < WORDS_L))
          region_o = RG_CHAN;
      end else begin
        case (addr_i)
          OFS_CAP_LO: region_o = RG_CAP_LO;
          OFS_CAP_HI: region_o = RG_CAP_HI;
          OFS_CFG_LO: region_o = RG_CFG_LO;
          OFS_CFG_HI: region_o = RG_CFG_HI;
          OFS_STAT:   region_o = RG_STAT;
          OFS_CNT_LO: region_o = RG_CNT_LO;
          OFS_CNT_HI: region_o = RG_CNT_HI;
          default:    region_o = RG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/etr_counter.sv
module etr_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [2*HALF_W-1:0] cnt_o
);
  localparam int CW = 2 * HALF_W;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_lo_i) cnt_q <= {cnt_q[CW-1:HALF_W], wdata_i};
    else if (wr_hi_i) cnt_q <= {wdata_i, cnt_q[HALF_W-1:0]};
    else if (en_i)    cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  // R5: a running counter with no write advances by exactly one
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wr_lo_i && !wr_hi_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R4: a halted counter with no write keeps its value
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  // R4: a low-half write leaves the high half alone
  p_half_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (cnt_q[CW-1:HALF_W] == $past(cnt_q[CW-1:HALF_W])));
endmodule

// File: rtl/etr_status.sv
module etr_status #(
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [NT-1:0] set_i,
  input  logic [NT-1:0] clr_i,
  input  logic          clr_all_i,
  output logic [NT-1:0] st_o
);
  logic [NT-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st_q <= '0;
    else if (clr_all_i) st_q <= '0;
    else                st_q <= (st_q & ~clr_i) | (en_i ? set_i : '0);
  end

  assign st_o = st_q;

  // R7: halting empties the status register
  p_halt_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (st_q == '0));
  // R8: no bit can appear while the counter is halted
  p_no_set_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ((st_q & ~$past(st_q)) == '0));
endmodule

// File: rtl/etr_main_regs.sv
module etr_main_regs
  import etr_pkg::*;
#(
  parameter int          NT          = 3,
  parameter logic [31:0] CAP_BASE    = 32'h8086A001,
  parameter logic [31:0] TICK_PERIOD = 32'd10_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [9:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic [NT-1:0]    ch_sel,
  output logic             ch_write,
  output logic [2:0]       ch_word,
  output logic [31:0]      ch_wdata,
  input  logic [NT*32-1:0] ch_rdata,
  input  logic [NT-1:0]    ch_cmp_max,
  output logic [NT-1:0]    ch_arm,
  output logic [NT-1:0]    ch_disarm,
  input  logic [NT-1:0]    ist_set,
  output logic             count_en,
  output logic             legacy_route,
  output logic [63:0]      count_value
);
  localparam int          NT_FIELD_LSB = 8;
  localparam logic [31:0] CAP_LO = CAP_BASE | (32'(NT - 1) << NT_FIELD_LSB);
  localparam int          CFG_BITS = 2;

  etr_region_e       region;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic              acc, wr, wr_cfg, rise, fall;
  logic [CFG_BITS-1:0] cfg_q;
  logic [NT-1:0]     st, clr_mask, arm_q, disarm_q;
  logic [63:0]       cnt;
  logic [31:0]       chan_rd, rd_val;

  etr_decode #(.NT(NT)) u_dec (
    .addr_i(req_addr), .region_o(region), .idx_o(idx), .word_o(word)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign wr_cfg    = wr && (region == RG_CFG_LO);
  assign rise      = wr_cfg && req_wdata[0] && !cfg_q[0];
  assign fall      = wr_cfg && !req_wdata[0] && cfg_q[0];
  assign clr_mask  = (wr && (region == RG_STAT)) ? req_wdata[NT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= req_wdata[CFG_BITS-1:0];
      arm_q    <= rise ? ~ch_cmp_max : '0;
      disarm_q <= fall ? '1 : '0;
    end
  end

  etr_counter #(.HALF_W(32)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_q[0]),
    .wr_lo_i(wr && (region == RG_CNT_LO)),
    .wr_hi_i(wr && (region == RG_CNT_HI)),
    .wdata_i(req_wdata), .cnt_o(cnt)
  );

  etr_status #(.NT(NT)) u_st (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_q[0]), .set_i(ist_set),
    .clr_i(clr_mask), .clr_all_i(fall), .st_o(st)
  );

  for (genvar g = 0; g < NT; g++) begin : g_sel
    assign ch_sel[g] = acc && (region == RG_CHAN) && (idx == IDX_W'(g));
  end

  assign ch_write = acc && (region == RG_CHAN) && req_write;
  assign ch_word  = word;
  assign ch_wdata = req_wdata;

  always_comb begin
    chan_rd = '0;
    for (int i = 0; i < NT; i++)
      if (idx == IDX_W'(i)) chan_rd = ch_rdata[i*32 +: 32];
  end

  always_comb begin
    case (region)
      RG_CAP_LO: rd_val = CAP_LO;
      RG_CAP_HI: rd_val = TICK_PERIOD;
      RG_CFG_LO: rd_val = 32'(cfg_q);
      RG_STAT:   rd_val = 32'(st);
      RG_CNT_LO: rd_val = cnt[31:0];
      RG_CNT_HI: rd_val = cnt[63:32];
      RG_CHAN:   rd_val = chan_rd;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign ch_arm       = arm_q;
  assign ch_disarm    = disarm_q;
  assign count_en     = cfg_q[0];
  assign legacy_route = cfg_q[1];
  assign count_value  = cnt;

  // R1: a stalled response keeps its data
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R9: at most one channel selected
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));
  // R9: every channel access produces a response next cycle
  p_sel_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_sel) |=> rsp_valid);
  // R6: starting the counter arms exactly the non-saturated channels
  p_arm_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_en) |-> (ch_arm == ~$past(ch_cmp_max)));
  // R6: arm and disarm never overlap
  p_arm_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_arm & ch_disarm) == '0);
  // R7: stopping the counter disarms every channel
  p_disarm_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(count_en) |-> (&ch_disarm));
endmodule

// File: tb/etr_main_regs_test.sv
`timescale 1ns/1ps
module etr_main_regs_test;
  localparam int NT = 3;
  localparam logic [31:0] EXP_CAP_LO = 32'h8086A201;
  localparam logic [31:0] EXP_PERIOD = 32'h00989680;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, ch_write, count_en, legacy_route;
  logic [31:0] rsp_rdata, ch_wdata;
  logic [NT-1:0] ch_sel, ch_arm, ch_disarm;
  logic [NT-1:0] ch_cmp_max = '0, ist_set = '0;
  logic [2:0] ch_word;
  logic [NT*32-1:0] ch_rdata;
  logic [63:0] count_value;

  int nvec = 0, nerr = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [63:0] held;

  always #2.5 clk = ~clk;

  etr_main_regs #(.NT(NT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ch_sel(ch_sel), .ch_write(ch_write), .ch_word(ch_word), .ch_wdata(ch_wdata),
    .ch_rdata(ch_rdata), .ch_cmp_max(ch_cmp_max), .ch_arm(ch_arm),
    .ch_disarm(ch_disarm), .ist_set(ist_set), .count_en(count_en),
    .legacy_route(legacy_route), .count_value(count_value)
  );

  // channel stand-in: channel i, word w answers {C5, i, 0, w}
  always_comb
    for (int i = 0; i < NT; i++)
      ch_rdata[i*32 +: 32] = {8'hC5, 8'(i), 13'h0, ch_word};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: pushes expected response, then presents the request
  task automatic access(input logic w, input logic [9:0] a, input logic [31:0] d,
                        input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    exp_q.push_back(e); tag_q.push_back(tag);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    access(1'b0, a, '0, e, tag);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    access(1'b1, a, d, 32'h0, tag);
  endtask

  task automatic chan(input logic w, input logic [9:0] a, input logic [31:0] d,
                      input logic [NT-1:0] esel, input logic [2:0] eword,
                      input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    exp_q.push_back(w ? 32'h0 : e); tag_q.push_back(tag);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    check({tag, " sel"}, 64'(ch_sel), 64'(esel));
    if (esel != '0) begin
      check({tag, " word"}, 64'(ch_word), 64'(eword));
      check({tag, " write"}, 64'(ch_write), 64'(w));
      if (w) check({tag, " wdata"}, 64'(ch_wdata), 64'(d));
    end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  // monitor: pops expectations as responses are consumed
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        nvec++; nerr++;
        $display("FAIL R1: actual unexpected response %h expected none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12 reset state
    check("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R12 req_ready", 64'(req_ready), 64'd1);
    check("R12 count", count_value, 64'd0);
    check("R12 pulses", 64'({ch_arm, ch_disarm}), 64'd0);
    rd(10'h010, 32'h0, "R12 cfg");
    rd(10'h020, 32'h0, "R12 status");
    rd(10'h0F4, 32'h0, "R12 count hi");

    // R2 capability
    rd(10'h000, EXP_CAP_LO, "R2 cap lo");
    rd(10'h004, EXP_PERIOD, "R2 period");
    wr(10'h000, 32'hFFFF_FFFF, "R2 wr");
    wr(10'h004, 32'h0, "R2 wr");
    rd(10'h000, EXP_CAP_LO, "R2 cap lo kept");
    rd(10'h004, EXP_PERIOD, "R2 period kept");

    // R3 configuration mask
    wr(10'h010, 32'hFFFF_FFFC, "R3 wr");
    rd(10'h010, 32'h0, "R3 masked");
    wr(10'h010, 32'h0000_0002, "R3 wr");
    rd(10'h010, 32'h2, "R3 legacy");
    check("R3 legacy pin", 64'(legacy_route), 64'd1);
    check("R3 not running", 64'(count_en), 64'd0);
    wr(10'h014, 32'hFFFF_FFFF, "R3 wr hi");
    rd(10'h014, 32'h0, "R3 hi zero");

    // R4 halted counter halves
    wr(10'h0F0, 32'h1234_5678, "R4 wr lo");
    wr(10'h0F4, 32'h0BAD_F00D, "R4 wr hi");
    rd(10'h0F0, 32'h1234_5678, "R4 lo");
    rd(10'h0F4, 32'h0BAD_F00D, "R4 hi");
    wr(10'h0F4, 32'h0000_000A, "R4 wr hi");
    rd(10'h0F0, 32'h1234_5678, "R4 lo untouched");
    wr(10'h0F0, 32'hFFFF_FFFE, "R4 wr lo");
    repeat (3) @(negedge clk);
    check("R4 holds", count_value, 64'h0000_000A_FFFF_FFFE);

    // R6 / R5 enable edge, counting and carry
    ch_cmp_max = 3'b010;
    wr(10'h010, 32'h0000_0001, "R5 enable");
    @(negedge clk); #1;
    check("R6 arm mask", 64'(ch_arm), 64'(3'b101));
    check("R5 start value", count_value, 64'h0000_000A_FFFF_FFFE);
    rd(10'h0F0, 32'hFFFF_FFFF, "R5 lo step");
    rd(10'h0F4, 32'h0000_000B, "R5 carry hi");
    rd(10'h0F0, 32'h0000_0001, "R5 lo wrapped");
    @(negedge clk); #1;
    check("R6 arm single cycle", 64'(ch_arm), 64'd0);
    wr(10'h010, 32'h0000_0003, "R6 rewrite");
    @(negedge clk); #1;
    check("R6 no arm without edge", 64'(ch_arm), 64'd0);

    // R8 status
    @(negedge clk); ist_set = 3'b101;
    @(negedge clk); ist_set = 3'b000;
    rd(10'h020, 32'h5, "R8 set");
    wr(10'h020, 32'h4, "R8 clear");
    rd(10'h020, 32'h1, "R8 partial clear");
    wr(10'h020, 32'h0, "R8 zero write");
    rd(10'h020, 32'h1, "R8 zero keeps");

    // R7 halt
    wr(10'h010, 32'h0, "R7 disable");
    @(negedge clk); #1;
    check("R7 disarm all", 64'(ch_disarm), 64'(3'b111));
    check("R6 no arm on halt", 64'(ch_arm), 64'd0);
    held = count_value;
    rd(10'h020, 32'h0, "R7 status cleared");
    rd(10'h0F0, held[31:0], "R7 held lo");
    repeat (10) @(negedge clk);
    rd(10'h0F4, held[63:32], "R7 held hi");
    @(negedge clk); ist_set = 3'b111;
    @(negedge clk); ist_set = 3'b000;
    rd(10'h020, 32'h0, "R8 halted ignores set");

    // R9 / R10 channel forwarding
    chan(1'b0, 10'h128, 32'h0, 3'b010, 3'd2, 32'hC501_0002, "R9 rd ch1 w2");
    chan(1'b1, 10'h140, 32'h0000_1234, 3'b100, 3'd0, 32'h0, "R9 wr ch2 w0");
    chan(1'b0, 10'h114, 32'h0, 3'b001, 3'd5, 32'hC500_0005, "R9 rd ch0 w5");
    chan(1'b0, 10'h160, 32'h0, 3'b000, 3'd0, 32'h0, "R10 index out");
    chan(1'b1, 10'h3E0, 32'hFFFF, 3'b000, 3'd0, 32'h0, "R10 top index");
    chan(1'b0, 10'h118, 32'h0, 3'b000, 3'd6, 32'h0, "R10 word six");

    // R11 unmapped and unaligned
    rd(10'h002, 32'h0, "R11 unaligned rd");
    rd(10'h0F8, 32'h0, "R11 hole rd");
    wr(10'h0F2, 32'hDEAD_BEEF, "R11 unaligned wr");
    wr(10'h012, 32'h0000_0001, "R11 unaligned cfg");
    rd(10'h0F0, held[31:0], "R11 count intact");
    rd(10'h010, 32'h0, "R11 cfg intact");

    // R1 back-pressure
    repeat (2) @(negedge clk);
    rsp_ready = 1'b0;
    rd(10'h004, EXP_PERIOD, "R1 stalled rd");
    @(negedge clk); #1;
    check("R1 blocked", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid held", 64'(rsp_valid), 64'd1);
    check("R1 data held", 64'(rsp_rdata), 64'(EXP_PERIOD));
    @(negedge clk); rsp_ready = 1'b1;
    rd(10'h000, EXP_CAP_LO, "R1 after stall");
    wr(10'h0F0, 32'h5, "R1 write response zero");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule